// File: doc/BRIEF.md
# Mailbox Receive-Complete Flag Register

This block keeps the per-mailbox completion status for a message controller with sixteen mailboxes. A receive engine reports each finished frame with a one-cycle event. The event carries the mailbox index, a bit that marks a remote frame, and a bit that marks the frame as error-free. For a good frame the block sets that mailbox's receive-complete flag. For a remote frame it also sets the mailbox's remote-request flag on the same clock edge.

Software sees two 16-bit status words through a small register port: one for receive-complete and one for remote-request. It acknowledges flags by writing ones. In both words the two bytes are exchanged relative to mailbox numbering. Two level outputs tell an interrupt controller whether any flag of each kind is pending. Mailbox 0 carries no flags.

Top module: `mbx_rxflag_regs`

## Requirements
- R1: After a synchronous reset, both flag words read 0 and both interrupt outputs are low.
- R2: A valid, error-free data-frame event (remote bit 0) for mailbox n, with 1 <= n <= 15, sets receive-complete flag n at the next rising edge and leaves remote-request flag n unchanged.
- R3: A valid, error-free remote-frame event (remote bit 1) for mailbox n, with 1 <= n <= 15, sets both receive-complete flag n and remote-request flag n at the same rising edge.
- R4: Host word layout: mailbox m (0..7) is at bit m+8 and mailbox m (8..15) is at bit m-8. Address 0 reads the receive-complete word and address 1 reads the remote-request word.
- R5: Writing a word to address 0 or 1 clears every flag of that word whose bit is 1 and leaves the flags whose bit is 0. A write never sets a flag.
- R6: If a good event and a host clear hit the same flag on the same edge, the flag ends up set.
- R7: Mailbox 0 (host bit 8) reads 0 in both words. An event naming mailbox 0 changes no flag.
- R8: An event with an index of 16 or above, or with the error-free bit low, changes no flag.
- R9: rx_irq is high exactly when any receive-complete flag is set, and rr_irq is high exactly when any remote-request flag is set.
- R10: Addresses 2 and 3 read as 0, and writes to them change no flag.
- R11: Read data follows the address and the flag state in the same cycle. A write is seen in read data only after the rising edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_evt_valid | input | 1 | One-cycle frame-complete event |
| rx_evt_mbx | input | 5 | Mailbox index of the event |
| rx_evt_remote | input | 1 | 1 = remote frame, 0 = data frame |
| rx_evt_ok | input | 1 | 1 = frame received without error |
| host_addr | input | 2 | Register select (0 receive-complete, 1 remote-request) |
| host_we | input | 1 | Write strobe |
| host_wdata | input | 16 | Write-one-to-clear data |
| host_rdata | output | 16 | Combinational read data |
| rx_irq | output | 1 | Any receive-complete flag pending |
| rr_irq | output | 1 | Any remote-request flag pending |

## Verification
The assertions check on every cycle that a good event always leaves its flags set, even when a clear arrives on the same edge. They also check that no flag rises without a qualifying event, that mailbox 0 stays clear, that a pending interrupt drops only after a host write, and that writes to unused addresses leave the state alone. The exact byte-exchanged bit positions, whether a frame with an error or an out-of-range index is ignored, and the cycle in which a write becomes visible can only be shown by the bench's directed scenarios. Those scenarios compare the read words and interrupt levels against a mailbox-ordered model.

// File: rtl/mbx_flag_pkg.sv
package mbx_flag_pkg;

  // Register selects on the host port
  localparam int HOST_ADDR_W = 2;
  localparam logic [HOST_ADDR_W-1:0] SEL_RXDONE = 2'd0;
  localparam logic [HOST_ADDR_W-1:0] SEL_RMTREQ = 2'd1;

  // Host bit i carries mailbox swap_src(i, w): the two halves are exchanged
  function automatic int swap_src(input int i, input int w);
    return (i + w / 2) % w;
  endfunction

endpackage

// File: rtl/mbx_evt_decode.sv
// Turns a frame-complete event into one-hot set vectors for both flag banks.
module mbx_evt_decode #(
  parameter int NUM_MBX   = 16,
  parameter int IDX_W     = 5,
  parameter int FIRST_MBX = 1
) (
  input  logic               evt_valid,
  input  logic [IDX_W-1:0]   evt_idx,
  input  logic               evt_remote,
  input  logic               evt_ok,
  output logic [NUM_MBX-1:0] rx_set,
  output logic [NUM_MBX-1:0] rr_set
);

  logic qualified;
  assign qualified = evt_valid & evt_ok;

  for (genvar m = 0; m < NUM_MBX; m++) begin : g_mbx
    if (m < FIRST_MBX) begin : g_none
      assign rx_set[m] = 1'b0;
      assign rr_set[m] = 1'b0;
    end else begin : g_hit
      logic hit;
      assign hit       = qualified & (evt_idx == IDX_W'(m));
      assign rx_set[m] = hit;
      assign rr_set[m] = hit & evt_remote;
    end
  end

endmodule

// File: rtl/mbx_w1c_bank.sv
// Sticky flag bank: hardware set has priority over a software clear.
module mbx_w1c_bank #(
  parameter int                  WIDTH     = 16,
  parameter logic [WIDTH-1:0]    IMPL_MASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] flags
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_flop
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= set_vec[i] | (q & ~clr_vec[i]);
      end
      assign flags[i] = q;
    end else begin : g_tie
      assign flags[i] = 1'b0;
    end
  end

endmodule

// File: rtl/mbx_host_swap.sv
// Exchanges the two halves of a word; the mapping is its own inverse.
module mbx_host_swap
  import mbx_flag_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam int SRC = swap_src(i, WIDTH);
    assign dout[i] = din[SRC];
  end

endmodule

// File: rtl/mbx_rxflag_regs.sv
module mbx_rxflag_regs
  import mbx_flag_pkg::*;
#(
  parameter int NUM_MBX   = 16,
  parameter int EVT_IDX_W = 5,
  parameter int FIRST_MBX = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rx_evt_valid,
  input  logic [EVT_IDX_W-1:0]   rx_evt_mbx,
  input  logic                   rx_evt_remote,
  input  logic                   rx_evt_ok,
  input  logic [HOST_ADDR_W-1:0] host_addr,
  input  logic                   host_we,
  input  logic [NUM_MBX-1:0]     host_wdata,
  output logic [NUM_MBX-1:0]     host_rdata,
  output logic                   rx_irq,
  output logic                   rr_irq
);

  localparam logic [NUM_MBX-1:0] IMPL_MASK = {NUM_MBX{1'b1}} << FIRST_MBX;

  logic [NUM_MBX-1:0] rx_set, rr_set;
  logic [NUM_MBX-1:0] wr_mbx;
  logic [NUM_MBX-1:0] rx_clr, rr_clr;
  logic [NUM_MBX-1:0] rx_flags, rr_flags;
  logic [NUM_MBX-1:0] rx_host, rr_host;

  mbx_evt_decode #(
    .NUM_MBX  (NUM_MBX),
    .IDX_W    (EVT_IDX_W),
    .FIRST_MBX(FIRST_MBX)
  ) u_decode (
    .evt_valid (rx_evt_valid),
    .evt_idx   (rx_evt_mbx),
    .evt_remote(rx_evt_remote),
    .evt_ok    (rx_evt_ok),
    .rx_set    (rx_set),
    .rr_set    (rr_set)
  );

  // Host write data into mailbox order
  mbx_host_swap #(.WIDTH(NUM_MBX)) u_swap_wr (.din(host_wdata), .dout(wr_mbx));

  always_comb begin
    rx_clr = '0;
    rr_clr = '0;
    if (host_we) begin
      if (host_addr == SEL_RXDONE) rx_clr = wr_mbx;
      if (host_addr == SEL_RMTREQ) rr_clr = wr_mbx;
    end
  end

  mbx_w1c_bank #(.WIDTH(NUM_MBX), .IMPL_MASK(IMPL_MASK)) u_rx_bank (
    .clk(clk), .rst(rst), .set_vec(rx_set), .clr_vec(rx_clr), .flags(rx_flags)
  );

  mbx_w1c_bank #(.WIDTH(NUM_MBX), .IMPL_MASK(IMPL_MASK)) u_rr_bank (
    .clk(clk), .rst(rst), .set_vec(rr_set), .clr_vec(rr_clr), .flags(rr_flags)
  );

  // Flag state into host order
  mbx_host_swap #(.WIDTH(NUM_MBX)) u_swap_rx (.din(rx_flags), .dout(rx_host));
  mbx_host_swap #(.WIDTH(NUM_MBX)) u_swap_rr (.din(rr_flags), .dout(rr_host));

  always_comb begin
    unique case (host_addr)
      SEL_RXDONE: host_rdata = rx_host;
      SEL_RMTREQ: host_rdata = rr_host;
      default:    host_rdata = '0;
    endcase
  end

  // Fed only from flops: no path from any input
  assign rx_irq = |rx_flags;
  assign rr_irq = |rr_flags;

endmodule

// File: rtl/mbx_rxflag_regs_chk.sv
module mbx_rxflag_regs_chk
  import mbx_flag_pkg::*;
#(
  parameter int NUM_MBX   = 16,
  parameter int EVT_IDX_W = 5,
  parameter int FIRST_MBX = 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   rx_evt_valid,
  input logic [EVT_IDX_W-1:0]   rx_evt_mbx,
  input logic                   rx_evt_remote,
  input logic                   rx_evt_ok,
  input logic [HOST_ADDR_W-1:0] host_addr,
  input logic                   host_we,
  input logic [NUM_MBX-1:0]     rx_flags,
  input logic [NUM_MBX-1:0]     rr_flags,
  input logic                   rx_irq,
  input logic                   rr_irq
);

  logic               good;
  logic [NUM_MBX-1:0] evt_oh;
  logic               wr_rx, wr_rr, wr_unused;

  assign good = rx_evt_valid && rx_evt_ok &&
                (int'(rx_evt_mbx) >= FIRST_MBX) && (int'(rx_evt_mbx) < NUM_MBX);
  assign evt_oh    = good ? (NUM_MBX'(1) << rx_evt_mbx) : '0;
  assign wr_rx     = host_we && (host_addr == SEL_RXDONE);
  assign wr_rr     = host_we && (host_addr == SEL_RMTREQ);
  assign wr_unused = host_we && !wr_rx && !wr_rr;

  // R1: reset clears both banks
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (rx_flags == '0 && rr_flags == '0));

  // R2 and R6: a good event leaves its receive-complete flag set, even against a clear
  a_r2_evt_sets_rx: assert property (@(posedge clk) disable iff (rst)
    good |=> ((rx_flags & $past(evt_oh)) == $past(evt_oh)));

  // R3 and R6: a good remote event sets the paired request flag on the same edge
  a_r3_remote_sets_rr: assert property (@(posedge clk) disable iff (rst)
    (good && rx_evt_remote) |=> ((rr_flags & $past(evt_oh)) == $past(evt_oh)));

  // R5/R8: no receive-complete flag rises without a qualifying event
  a_r5_no_sw_set_rx: assert property (@(posedge clk) disable iff (rst)
    !good |=> ((rx_flags & ~$past(rx_flags)) == '0));

  // R2/R5: no request flag rises without a good remote event
  a_r2_no_rr_on_data: assert property (@(posedge clk) disable iff (rst)
    !(good && rx_evt_remote) |=> ((rr_flags & ~$past(rr_flags)) == '0));

  // R7: mailbox 0 never holds a flag
  a_r7_mbx0_clear: assert property (@(posedge clk) disable iff (rst)
    (rx_flags[0] == 1'b0 && rr_flags[0] == 1'b0));

  // R9: a pending interrupt drops only after a host write to its word
  a_r9_rx_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (rx_irq && !wr_rx) |=> rx_irq);
  a_r9_rr_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (rr_irq && !wr_rr) |=> rr_irq);

  // R10: writes to unused addresses with no event leave both banks alone
  a_r10_unused_write: assert property (@(posedge clk) disable iff (rst)
    (wr_unused && !good) |=> ($stable(rx_flags) && $stable(rr_flags)));

endmodule

bind mbx_rxflag_regs mbx_rxflag_regs_chk #(
  .NUM_MBX  (NUM_MBX),
  .EVT_IDX_W(EVT_IDX_W),
  .FIRST_MBX(FIRST_MBX)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rx_evt_valid (rx_evt_valid),
  .rx_evt_mbx   (rx_evt_mbx),
  .rx_evt_remote(rx_evt_remote),
  .rx_evt_ok    (rx_evt_ok),
  .host_addr    (host_addr),
  .host_we      (host_we),
  .rx_flags     (rx_flags),
  .rr_flags     (rr_flags),
  .rx_irq       (rx_irq),
  .rr_irq       (rr_irq)
);

// File: tb/mbx_rxflag_regs_bench.sv
module mbx_rxflag_regs_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_evt_valid = 1'b0;
  logic [4:0]  rx_evt_mbx = '0;
  logic        rx_evt_remote = 1'b0;
  logic        rx_evt_ok = 1'b0;
  logic [1:0]  host_addr = '0;
  logic        host_we = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        rx_irq, rr_irq;

  int n_tests = 0;
  int n_fail  = 0;

  // Model in mailbox order
  logic [15:0] m_rx = '0;
  logic [15:0] m_rr = '0;

  always #4 clk = ~clk;

  mbx_rxflag_regs u_mbx_rxflag_regs (
    .clk(clk), .rst(rst),
    .rx_evt_valid(rx_evt_valid), .rx_evt_mbx(rx_evt_mbx),
    .rx_evt_remote(rx_evt_remote), .rx_evt_ok(rx_evt_ok),
    .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .rx_irq(rx_irq), .rr_irq(rr_irq)
  );

  function automatic logic [15:0] xchg(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    host_addr = a;
    #1 v = host_rdata;
  endtask

  // Compare both words and both interrupt levels with the model
  task automatic check_all(input string req);
    logic [15:0] v;
    rd(2'd0, v); chk(req, "rx word", v, xchg(m_rx));
    rd(2'd1, v); chk(req, "rr word", v, xchg(m_rr));
    chk(req, "rx_irq", 16'(rx_irq), 16'(|m_rx));
    chk(req, "rr_irq", 16'(rr_irq), 16'(|m_rr));
  endtask

  // One clock of stimulus; model applies clear first, then set
  task automatic cycle(input logic ev, input logic [4:0] idx, input logic rmt,
                       input logic ok, input logic we, input logic [1:0] a,
                       input logic [15:0] wd);
    logic [15:0] setv;
    @(negedge clk);
    rx_evt_valid = ev; rx_evt_mbx = idx; rx_evt_remote = rmt; rx_evt_ok = ok;
    host_we = we; host_addr = a; host_wdata = wd;
    @(negedge clk);
    rx_evt_valid = 1'b0; host_we = 1'b0;
    setv = '0;
    if (ev && ok && idx >= 5'd1 && idx <= 5'd15) setv[idx[3:0]] = 1'b1;
    if (we && a == 2'd0) m_rx = m_rx & ~xchg(wd);
    if (we && a == 2'd1) m_rr = m_rr & ~xchg(wd);
    m_rx = m_rx | setv;
    if (rmt) m_rr = m_rr | setv;
  endtask

  task automatic evt(input logic [4:0] idx, input logic rmt, input logic ok);
    cycle(1'b1, idx, rmt, ok, 1'b0, 2'd0, 16'h0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] wd);
    cycle(1'b0, 5'd0, 1'b0, 1'b0, 1'b1, a, wd);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_rx = '0; m_rr = '0;
    rd(2'd0, v); chk("R1", "rx after reset", v, 16'h0000);
    rd(2'd1, v); chk("R1", "rr after reset", v, 16'h0000);
    chk("R1", "irqs after reset", {14'b0, rx_irq, rr_irq}, 16'h0);
  endtask

  task automatic t_data;
    logic [15:0] v;
    evt(5'd3, 1'b0, 1'b1);
    rd(2'd0, v); chk("R4", "mbx3 at bit 11", v, 16'h0800);
    rd(2'd1, v); chk("R2", "data frame leaves rr", v, 16'h0000);
    evt(5'd12, 1'b0, 1'b1);
    rd(2'd0, v); chk("R4", "mbx12 at bit 4", v, 16'h0810);
    evt(5'd15, 1'b0, 1'b1);
    evt(5'd7, 1'b0, 1'b1);
    rd(2'd0, v); chk("R4", "mbx15 bit7 mbx7 bit15", v, 16'h8890);
    check_all("R2");
  endtask

  task automatic t_remote;
    logic [15:0] v;
    evt(5'd9, 1'b1, 1'b1);
    rd(2'd1, v); chk("R3", "rr mbx9 at bit 1", v, 16'h0002);
    rd(2'd0, v); chk("R3", "rx mbx9 same edge", v & 16'h0002, 16'h0002);
    check_all("R3");
  endtask

  task automatic t_w1c;
    logic [15:0] v;
    wr(2'd0, 16'h0000);
    check_all("R5");
    // R11: the write shows only after its sampling edge
    @(negedge clk);
    host_we = 1'b1; host_addr = 2'd0; host_wdata = 16'h0800;
    #1 chk("R11", "old value during write cycle", host_rdata, xchg(m_rx));
    @(negedge clk);
    host_we = 1'b0;
    m_rx = m_rx & ~xchg(16'h0800);
    #1 chk("R11", "cleared after edge", host_rdata & 16'h0800, 16'h0000);
    wr(2'd0, 16'hFFFF);
    check_all("R5");
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); chk("R5", "ones never set", v, 16'h0000);
    rd(2'd1, v); chk("R5", "rr kept by rx clear", v, 16'h0002);
    wr(2'd1, 16'h0002);
    check_all("R5");
  endtask

  task automatic t_set_wins;
    logic [15:0] v;
    evt(5'd5, 1'b0, 1'b1);
    cycle(1'b1, 5'd5, 1'b0, 1'b1, 1'b1, 2'd0, 16'h2000);
    rd(2'd0, v); chk("R6", "set beats clear mbx5", v, 16'h2000);
    cycle(1'b1, 5'd6, 1'b1, 1'b1, 1'b1, 2'd1, 16'hFFFF);
    rd(2'd1, v); chk("R6", "rr set beats clear mbx6", v, 16'h4000);
    check_all("R6");
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'hFFFF);
  endtask

  task automatic t_mbx0;
    logic [15:0] v;
    evt(5'd0, 1'b0, 1'b1);
    evt(5'd0, 1'b1, 1'b1);
    rd(2'd0, v); chk("R7", "mbx0 rx bit8", v, 16'h0000);
    rd(2'd1, v); chk("R7", "mbx0 rr bit8", v, 16'h0000);
    chk("R7", "irq after mbx0", {14'b0, rx_irq, rr_irq}, 16'h0);
  endtask

  task automatic t_bad;
    logic [15:0] v;
    evt(5'd16, 1'b1, 1'b1);
    evt(5'd31, 1'b0, 1'b1);
    evt(5'd4, 1'b1, 1'b0);
    rd(2'd0, v); chk("R8", "bad events rx", v, 16'h0000);
    rd(2'd1, v); chk("R8", "bad events rr", v, 16'h0000);
    cycle(1'b0, 5'd2, 1'b1, 1'b1, 1'b0, 2'd0, 16'h0);
    rd(2'd0, v); chk("R8", "no valid no change", v, 16'h0000);
  endtask

  task automatic t_irq;
    evt(5'd10, 1'b1, 1'b1);
    check_all("R9");
    wr(2'd0, 16'h0004);
    chk("R9", "rx_irq low", 16'(rx_irq), 16'h0);
    chk("R9", "rr_irq still high", 16'(rr_irq), 16'h1);
    wr(2'd1, 16'h0004);
    check_all("R9");
  endtask

  task automatic t_unused;
    logic [15:0] v;
    evt(5'd1, 1'b1, 1'b1);
    evt(5'd8, 1'b0, 1'b1);
    wr(2'd2, 16'hFFFF);
    wr(2'd3, 16'hFFFF);
    rd(2'd2, v); chk("R10", "addr2 reads 0", v, 16'h0000);
    rd(2'd3, v); chk("R10", "addr3 reads 0", v, 16'h0000);
    rd(2'd0, v); chk("R10", "rx kept", v, 16'h0201);
    check_all("R10");
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_data();
    t_remote();
    t_w1c();
    t_set_wins();
    t_mbx0();
    t_bad();
    t_irq();
    t_unused();
    t_reset();
    check_all("R1");
    finish_run();
  end

endmodule